// File: doc/BRIEF.md
# ASN-Tagged Fully Associative Translation Buffer

This block is a small fully associative cache of page table entries. Each slot holds a virtual page number as its tag, the physical page number it maps to, an address space number, a global flag, per-privilege-mode read and write permission masks, and two fault-on-access flags. A lookup presents a virtual page number together with the current address space number. Within the same cycle, the block reports whether a valid slot matches and returns that slot's fields. A slot matches when its tag is equal to the virtual page number and either its global flag is set or its stored address space number is equal to the presented one.

New entries are written through an insert port. The slot to fill is chosen by a round-robin replacement pointer, which wraps at the entry count. A flush-by-address port removes every entry that the lookup rule would match for a given page number and address space number, so global entries are removed whatever address space number is given. A flush-all input empties the buffer and returns the pointer to slot zero. Inserts and flushes take effect at the next clock edge. Page table walking, permission policy and fault reporting are left to the surrounding logic.

Top module: `asn_tlb`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses (lu_hit = 0), and the replacement pointer is at slot 0.
- R2: An insert stores its page number as the tag of the slot under the pointer and marks that slot valid. From the next clock edge, a lookup with the same page number and address space number hits and returns the inserted physical page number.
- R3: A lookup is combinational. It hits only on a valid slot whose tag equals lu_vpn and which is either global or holds an address space number equal to lu_asn. A non-global entry does not hit for a different address space number or for a different page number.
- R4: A global entry hits for every value of lu_asn.
- R5: Each insert advances the pointer by one slot, and the pointer wraps from slot 7 (N-1) to slot 0. An insert into an occupied slot replaces it at the same edge, so the old tag stops hitting while the other slots stay intact.
- R6: A flush by address invalidates every valid slot whose tag equals fl_vpn and which is either global or holds an address space number equal to fl_asn. All other slots are left untouched.
- R7: When several valid slots match a lookup, the slot with the lowest index supplies the returned fields.
- R8: flush_all clears every valid bit and sets the pointer to slot 0, so the next insert goes to slot 0. flush_all takes precedence over an insert or a flush in the same cycle.
- R9: On a hit the block returns the slot's physical page number, address space number, global flag, read-enable mask, write-enable mask (bit m is mode m), fault-on-read flag and fault-on-write flag. On a miss all of these read as zero.
- R10: When an insert and a flush by address occur in the same cycle, the flush acts on the other slots, and the slot being filled takes the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | Invalidate all slots and reset the pointer |
| ins_valid | input | 1 | Insert strobe |
| ins_vpn | input | 30 | Tag for the new entry |
| ins_ppn | input | 28 | Physical page number for the new entry |
| ins_asn | input | 8 | Address space number for the new entry |
| ins_global | input | 1 | Global flag for the new entry |
| ins_rd_en | input | 4 | Per-mode read enables |
| ins_wr_en | input | 4 | Per-mode write enables |
| ins_fault_rd | input | 1 | Fault-on-read flag |
| ins_fault_wr | input | 1 | Fault-on-write flag |
| fl_valid | input | 1 | Flush-by-address strobe |
| fl_vpn | input | 30 | Page number to flush |
| fl_asn | input | 8 | Address space number to flush |
| lu_vpn | input | 30 | Lookup page number |
| lu_asn | input | 8 | Current address space number |
| lu_hit | output | 1 | Lookup hit |
| lu_ppn | output | 28 | Physical page number of the hit slot |
| lu_asn_out | output | 8 | Stored address space number of the hit slot |
| lu_global | output | 1 | Global flag of the hit slot |
| lu_rd_en | output | 4 | Read enables of the hit slot |
| lu_wr_en | output | 4 | Write enables of the hit slot |
| lu_fault_rd | output | 1 | Fault-on-read flag of the hit slot |
| lu_fault_wr | output | 1 | Fault-on-write flag of the hit slot |

## Verification
The bench targets four corner cases. The first is a flush with one address space number on a page that also holds a global entry and an entry for another address space: a design that skipped the global term would leave a stale global mapping, and one that ignored the address space number would remove the other process's entry. The second fills all eight slots and then inserts once more, to catch a pointer that fails to wrap or an overwrite that leaves the old tag still hitting. The third loads duplicate tags to check lowest-index priority, and it also detects a flush-all that clears the valid bits but leaves the pointer where it was, because the later duplicate would then land in a lower slot and win. The last is an insert together with a flush in the same cycle, which shows whether the flush wrongly removes the slot being filled.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int TLB_ENTRIES   = 8;
    localparam int TLB_VPN_W     = 30;
    localparam int TLB_PPN_W     = 28;
    localparam int TLB_ASN_W     = 8;
    localparam int TLB_MODES     = 4;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int VPN_W = 30,
    parameter int ASN_W = 8
) (
    input  logic             slot_valid,
    input  logic [VPN_W-1:0] slot_tag,
    input  logic [ASN_W-1:0] slot_asn,
    input  logic             slot_global,
    input  logic [VPN_W-1:0] key_vpn,
    input  logic [ASN_W-1:0] key_asn,
    output logic             match
);
    logic tag_eq;
    logic asn_ok;

    always_comb begin
        tag_eq = (slot_tag == key_vpn);
        asn_ok = slot_global || (slot_asn == key_asn);
        match  = slot_valid && tag_eq && asn_ok;
    end
endmodule

// File: rtl/tlb_prio_pick.sv
module tlb_prio_pick #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
    import tlb_pkg::*;
#(
    parameter int N     = TLB_ENTRIES,
    parameter int VPN_W = TLB_VPN_W,
    parameter int PPN_W = TLB_PPN_W,
    parameter int ASN_W = TLB_ASN_W,
    parameter int MODES = TLB_MODES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_all,
    input  logic             ins_valid,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic [ASN_W-1:0] ins_asn,
    input  logic             ins_global,
    input  logic [MODES-1:0] ins_rd_en,
    input  logic [MODES-1:0] ins_wr_en,
    input  logic             ins_fault_rd,
    input  logic             ins_fault_wr,
    input  logic             fl_valid,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [ASN_W-1:0] fl_asn,
    input  logic [VPN_W-1:0] lu_vpn,
    input  logic [ASN_W-1:0] lu_asn,
    output logic             lu_hit,
    output logic [PPN_W-1:0] lu_ppn,
    output logic [ASN_W-1:0] lu_asn_out,
    output logic             lu_global,
    output logic [MODES-1:0] lu_rd_en,
    output logic [MODES-1:0] lu_wr_en,
    output logic             lu_fault_rd,
    output logic             lu_fault_wr
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(N - 1);

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
        logic [ASN_W-1:0] asn;
        logic             glob;
        logic [MODES-1:0] rd_en;
        logic [MODES-1:0] wr_en;
        logic             f_rd;
        logic             f_wr;
    } slot_t;

    typedef struct packed {
        slot_t [N-1:0]    slot;
        logic [IDX_W-1:0] ptr;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0]     lu_match;
    logic [N-1:0]     fl_match;
    logic [IDX_W-1:0] hit_idx;
    logic             any_hit;
    slot_t            sel;
    slot_t            new_slot;

    // one comparator pair per slot: lookup key and flush key
    for (genvar i = 0; i < N; i++) begin : g_slot
        tlb_match #(.VPN_W(VPN_W), .ASN_W(ASN_W)) u_lu_cmp (
            .slot_valid  (st_q.slot[i].valid),
            .slot_tag    (st_q.slot[i].tag),
            .slot_asn    (st_q.slot[i].asn),
            .slot_global (st_q.slot[i].glob),
            .key_vpn     (lu_vpn),
            .key_asn     (lu_asn),
            .match       (lu_match[i])
        );
        tlb_match #(.VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_cmp (
            .slot_valid  (st_q.slot[i].valid),
            .slot_tag    (st_q.slot[i].tag),
            .slot_asn    (st_q.slot[i].asn),
            .slot_global (st_q.slot[i].glob),
            .key_vpn     (fl_vpn),
            .key_asn     (fl_asn),
            .match       (fl_match[i])
        );
    end

    tlb_prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .req (lu_match),
        .any (any_hit),
        .idx (hit_idx)
    );

    // lookup result: fields of the lowest matching slot, zero on miss
    always_comb begin
        sel         = st_q.slot[hit_idx];
        lu_hit      = any_hit;
        lu_ppn      = any_hit ? sel.ppn   : '0;
        lu_asn_out  = any_hit ? sel.asn   : '0;
        lu_global   = any_hit && sel.glob;
        lu_rd_en    = any_hit ? sel.rd_en : '0;
        lu_wr_en    = any_hit ? sel.wr_en : '0;
        lu_fault_rd = any_hit && sel.f_rd;
        lu_fault_wr = any_hit && sel.f_wr;
    end

    // next state
    always_comb begin
        new_slot.valid = 1'b1;
        new_slot.tag   = ins_vpn;
        new_slot.ppn   = ins_ppn;
        new_slot.asn   = ins_asn;
        new_slot.glob  = ins_global;
        new_slot.rd_en = ins_rd_en;
        new_slot.wr_en = ins_wr_en;
        new_slot.f_rd  = ins_fault_rd;
        new_slot.f_wr  = ins_fault_wr;

        st_d = st_q;
        if (flush_all) begin
            for (int i = 0; i < N; i++) begin
                st_d.slot[i].valid = 1'b0;
            end
            st_d.ptr = '0;
        end else begin
            if (fl_valid) begin
                for (int i = 0; i < N; i++) begin
                    if (fl_match[i]) begin
                        st_d.slot[i].valid = 1'b0;
                    end
                end
            end
            if (ins_valid) begin
                st_d.slot[st_q.ptr] = new_slot;
                st_d.ptr = (st_q.ptr == LAST_SLOT) ? '0 : st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
    parameter int N     = 8,
    parameter int VPN_W = 30,
    parameter int PPN_W = 28,
    parameter int ASN_W = 8,
    parameter int MODES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush_all,
    input logic             ins_valid,
    input logic [VPN_W-1:0] ins_vpn,
    input logic [ASN_W-1:0] ins_asn,
    input logic             fl_valid,
    input logic [VPN_W-1:0] fl_vpn,
    input logic [ASN_W-1:0] fl_asn,
    input logic [VPN_W-1:0] lu_vpn,
    input logic [ASN_W-1:0] lu_asn,
    input logic             lu_hit,
    input logic [PPN_W-1:0] lu_ppn,
    input logic [ASN_W-1:0] lu_asn_out,
    input logic             lu_global,
    input logic [MODES-1:0] lu_rd_en,
    input logic [MODES-1:0] lu_wr_en,
    input logic             lu_fault_rd,
    input logic             lu_fault_wr
);
    // R1 / R8: nothing survives a flush_all
    assert_flush_all_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !lu_hit);

    // R3 / R4: a hit is global or carries the presented address space number
    assert_hit_asn_rule_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lu_hit |-> (lu_global || (lu_asn_out == lu_asn)));

    // R9: a miss returns zero fields
    assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lu_hit |-> (lu_ppn == '0 && lu_rd_en == '0 && lu_wr_en == '0 &&
                     !lu_global && !lu_fault_rd && !lu_fault_wr));

    // R2: a just-inserted key hits
    assert_insert_hits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !flush_all) |=>
            ((lu_vpn == $past(ins_vpn) && lu_asn == $past(ins_asn)) -> lu_hit));

    // R6: a just-flushed key misses (no insert in the same cycle)
    assert_flush_removes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && !ins_valid) |=>
            !(lu_hit && lu_vpn == $past(fl_vpn) && lu_asn == $past(fl_asn)));
endmodule

bind asn_tlb tlb_chk #(
    .N(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W), .MODES(MODES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
    .ins_valid(ins_valid), .ins_vpn(ins_vpn), .ins_asn(ins_asn),
    .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_asn(fl_asn),
    .lu_vpn(lu_vpn), .lu_asn(lu_asn), .lu_hit(lu_hit), .lu_ppn(lu_ppn),
    .lu_asn_out(lu_asn_out), .lu_global(lu_global), .lu_rd_en(lu_rd_en),
    .lu_wr_en(lu_wr_en), .lu_fault_rd(lu_fault_rd), .lu_fault_wr(lu_fault_wr)
);

// File: tb/tb_asn_tlb.sv
module tb_asn_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_all = 1'b0;
    logic        ins_valid = 1'b0;
    logic [29:0] ins_vpn = '0;
    logic [27:0] ins_ppn = '0;
    logic [7:0]  ins_asn = '0;
    logic        ins_global = 1'b0;
    logic [3:0]  ins_rd_en = '0;
    logic [3:0]  ins_wr_en = '0;
    logic        ins_fault_rd = 1'b0;
    logic        ins_fault_wr = 1'b0;
    logic        fl_valid = 1'b0;
    logic [29:0] fl_vpn = '0;
    logic [7:0]  fl_asn = '0;
    logic [29:0] lu_vpn = '0;
    logic [7:0]  lu_asn = '0;
    logic        lu_hit;
    logic [27:0] lu_ppn;
    logic [7:0]  lu_asn_out;
    logic        lu_global;
    logic [3:0]  lu_rd_en;
    logic [3:0]  lu_wr_en;
    logic        lu_fault_rd;
    logic        lu_fault_wr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    asn_tlb dut (.*);

    task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic insert(input logic [29:0] v, input logic [27:0] p, input logic [7:0] a,
                          input logic g, input logic [3:0] rd, input logic [3:0] wr,
                          input logic fr, input logic fw);
        ins_valid = 1'b1; ins_vpn = v; ins_ppn = p; ins_asn = a; ins_global = g;
        ins_rd_en = rd; ins_wr_en = wr; ins_fault_rd = fr; ins_fault_wr = fw;
        tick();
        ins_valid = 1'b0;
    endtask

    task automatic ins_simple(input logic [29:0] v, input logic [27:0] p, input logic [7:0] a,
                              input logic g);
        insert(v, p, a, g, 4'hF, 4'hF, 1'b0, 1'b0);
    endtask

    task automatic flush_addr(input logic [29:0] v, input logic [7:0] a);
        fl_valid = 1'b1; fl_vpn = v; fl_asn = a;
        tick();
        fl_valid = 1'b0;
    endtask

    task automatic do_flush_all();
        flush_all = 1'b1;
        tick();
        flush_all = 1'b0;
    endtask

    task automatic look(input logic [29:0] v, input logic [7:0] a);
        lu_vpn = v; lu_asn = a;
        #1;
    endtask

    task automatic t_reset();
        look(30'h0, 8'h0);
        check_eq("R1 miss vpn0 after reset", lu_hit, 0);
        look(30'h1234, 8'h5);
        check_eq("R1 miss vpn1234 after reset", lu_hit, 0);
        check_eq("R9 ppn zero on miss", lu_ppn, 0);
    endtask

    task automatic t_basic();
        insert(30'h1234, 28'hABC, 8'h05, 1'b0, 4'b0011, 4'b0001, 1'b1, 1'b0);
        look(30'h1234, 8'h05);
        check_eq("R2 hit after insert", lu_hit, 1);
        check_eq("R2 ppn", lu_ppn, 28'hABC);
        check_eq("R9 asn", lu_asn_out, 8'h05);
        check_eq("R9 global", lu_global, 0);
        check_eq("R9 rd_en", lu_rd_en, 4'b0011);
        check_eq("R9 wr_en", lu_wr_en, 4'b0001);
        check_eq("R9 fault_rd", lu_fault_rd, 1);
        check_eq("R9 fault_wr", lu_fault_wr, 0);
        look(30'h1234, 8'h06);
        check_eq("R3 miss on other asn", lu_hit, 0);
        look(30'h1235, 8'h05);
        check_eq("R3 miss on other vpn", lu_hit, 0);
    endtask

    task automatic t_global();
        insert(30'h2000, 28'h77, 8'h09, 1'b1, 4'b1000, 4'b0100, 1'b0, 1'b1);
        look(30'h2000, 8'h00);
        check_eq("R4 global hit asn0", lu_hit, 1);
        check_eq("R4 global ppn", lu_ppn, 28'h77);
        check_eq("R9 fault_wr global", lu_fault_wr, 1);
        look(30'h2000, 8'hFF);
        check_eq("R4 global hit asnFF", lu_hit, 1);
    endtask

    task automatic t_flush();
        do_flush_all();
        ins_simple(30'h300, 28'hA1, 8'h01, 1'b0);
        ins_simple(30'h300, 28'hB2, 8'h02, 1'b0);
        ins_simple(30'h300, 28'hC3, 8'h07, 1'b1);
        ins_simple(30'h301, 28'hD4, 8'h01, 1'b0);
        flush_addr(30'h300, 8'h01);
        look(30'h300, 8'h01);
        check_eq("R6 matching and global removed", lu_hit, 0);
        look(30'h300, 8'h02);
        check_eq("R6 other asn kept hit", lu_hit, 1);
        check_eq("R6 other asn kept ppn (global gone)", lu_ppn, 28'hB2);
        look(30'h301, 8'h01);
        check_eq("R6 other vpn kept", lu_hit, 1);
    endtask

    task automatic t_prio();
        do_flush_all();
        ins_simple(30'h40, 28'h11, 8'h03, 1'b0);
        ins_simple(30'h40, 28'h22, 8'h0E, 1'b1);
        look(30'h40, 8'h03);
        check_eq("R7 lowest index wins", lu_ppn, 28'h11);
        look(30'h40, 8'h04);
        check_eq("R7 only global matches", lu_ppn, 28'h22);
    endtask

    task automatic t_wrap();
        do_flush_all();
        for (int i = 0; i < 8; i++) begin
            ins_simple(30'h500 + 30'(i), 28'(i + 1), 8'h01, 1'b0);
        end
        look(30'h507, 8'h01);
        check_eq("R5 slot7 filled", lu_ppn, 28'h8);
        ins_simple(30'h600, 28'h99, 8'h01, 1'b0);
        look(30'h500, 8'h01);
        check_eq("R5 wrapped slot0 old tag gone", lu_hit, 0);
        look(30'h600, 8'h01);
        check_eq("R5 new entry hits", lu_ppn, 28'h99);
        look(30'h501, 8'h01);
        check_eq("R5 neighbour intact", lu_ppn, 28'h2);
    endtask

    task automatic t_flush_all_ptr();
        do_flush_all();
        for (int i = 0; i < 3; i++) begin
            ins_simple(30'h800 + 30'(i), 28'h5, 8'h01, 1'b0);
        end
        do_flush_all();
        look(30'h800, 8'h01);
        check_eq("R8 flush_all empties", lu_hit, 0);
        ins_simple(30'h900, 28'h1, 8'h02, 1'b0);
        for (int i = 0; i < 6; i++) begin
            ins_simple(30'hA00 + 30'(i), 28'h3, 8'h02, 1'b0);
        end
        ins_simple(30'h900, 28'h2, 8'h02, 1'b0);
        look(30'h900, 8'h02);
        check_eq("R8 pointer reset to slot0", lu_ppn, 28'h1);
    endtask

    task automatic t_same_cycle();
        do_flush_all();
        ins_simple(30'h700, 28'h10, 8'h01, 1'b0);
        fl_valid = 1'b1; fl_vpn = 30'h700; fl_asn = 8'h01;
        ins_valid = 1'b1; ins_vpn = 30'h700; ins_ppn = 28'h20; ins_asn = 8'h01;
        ins_global = 1'b0;
        tick();
        fl_valid = 1'b0; ins_valid = 1'b0;
        look(30'h700, 8'h01);
        check_eq("R10 new entry survives flush", lu_hit, 1);
        check_eq("R10 old entry flushed", lu_ppn, 28'h20);
        flush_all = 1'b1; ins_valid = 1'b1; ins_vpn = 30'h710; ins_asn = 8'h01;
        tick();
        flush_all = 1'b0; ins_valid = 1'b0;
        look(30'h710, 8'h01);
        check_eq("R8 flush_all beats insert", lu_hit, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_global();
        t_flush();
        t_prio();
        t_wrap();
        t_flush_all_ptr();
        t_same_cycle();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule